// File: doc/BRIEF.md
# Zero-Turnaround Late-Write Synchronous SRAM

This block is an on-chip synchronous memory whose interface lets reads and writes follow one another on every clock with no idle cycle when the bus changes direction. Each command is captured on a rising edge: address, write select, per-byte write strobes, three chip selects, the clock enable and a load/advance control. The write data for a command does not come with it. It comes on a later edge, so the data bus carries read results and write payloads in an interleaved stream.

A static strap selects one of two latencies. In registered mode, read data passes through an extra output register and write data follows its command by two enabled edges. In direct mode, read data comes straight from the read stage and write data follows by one enabled edge. Because writes are committed late, a read can target a word whose write has been issued but is not yet in the array. Address comparators against the pending write stages forward the newest bytes, so every read returns the value in command order.

Short bursts of four words are started by a load command and continued with advance cycles. The two low address bits step in either linear or interleaved order. The data bus appears as separate input, output and drive-enable signals. A clock-enable freeze, an asynchronous output disable and a sleep input complete the interface.

Top module: `nbt_sram`

## Requirements
- R1: After synchronous reset (`rst_n` low) the block does not drive the bus (`dq_oe` = 0) until a read completes.
- R2: A command is accepted only when `cs_a_n`=0, `cs_b`=1 and `cs_c_n`=0. Any other combination on a load cycle is a deselect: no write is performed and no read data is driven.
- R3: Registered mode (`flow_mode`=0): a read captured on enabled edge k drives `dout` with `dq_oe`=1 after enabled edge k+1, until the next enabled edge.
- R4: Direct mode (`flow_mode`=1): a read captured on enabled edge k drives `dout` with `dq_oe`=1 after edge k, until the next enabled edge.
- R5: The write data for a command captured on enabled edge k is sampled from `din` on enabled edge k+2 in registered mode and k+1 in direct mode, and it is committed on that edge.
- R6: Byte lane i is bits [9i+8:9i]. It is written only when `byte_wr_n[i]`=0 in the cycle the write command is issued. The other lanes keep their contents.
- R7: A read returns the latest value in command order, with the enabled bytes of every earlier write applied, including writes whose data has not yet been committed.
- R8: `load`=1 starts a command at `addr`. `load`=0 continues the last loaded command at the next burst offset. Offset n (n=1,2,3, then wrapping) replaces the two low address bits with base+n mod 4 when `lin_order`=1, or with base XOR n when `lin_order`=0. The write strobes are taken in each cycle.
- R9: While `clk_en_n`=1, no state changes: `din` and the command inputs are ignored and `dout`/`dq_oe` hold.
- R10: `oe_n`=1 forces `dq_oe`=0 at once, without waiting for a clock edge.
- R11: While `sleep`=1, a new command is ignored and the burst state is held. Writes already pending still take their data and commit.
- R12: Deselect or sleep cycles between a write command and its data edge do not disturb that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_en_n | input | 1 | Active-low clock enable; high freezes all state |
| sleep | input | 1 | Active-high power-down; new commands ignored |
| flow_mode | input | 1 | Static strap: 1 direct mode, 0 registered mode |
| lin_order | input | 1 | Static strap: 1 linear burst, 0 interleaved burst |
| load | input | 1 | 1 loads a new command, 0 advances the burst |
| wr_n | input | 1 | Active-low write select on load cycles |
| cs_a_n | input | 1 | Chip select, active low |
| cs_b | input | 1 | Chip select, active high |
| cs_c_n | input | 1 | Chip select, active low |
| byte_wr_n | input | NBYTES (2) | Active-low per-lane write strobes |
| addr | input | ADDR_W (6) | Word address |
| din | input | NBYTES*BYTE_W (18) | Late write data |
| oe_n | input | 1 | Asynchronous active-low output enable |
| dout | output | NBYTES*BYTE_W (18) | Read data |
| dq_oe | output | 1 | Bus drive enable for `dout` |

## Verification
The hardest situation to reach is a read whose address matches two writes that are still in flight at the same moment. In registered mode, one of those writes has its data on `din` during the read's capture edge and the other delivers its data one edge later, and the two may enable different byte lanes. The stimulus issues two partial writes to one word back to back and then a read of that word on the next edge. It repeats the pattern with stalled clock-enable cycles and deselect or sleep bubbles placed between command and data. Bursts are also turned from write to read with no gap, and every returned word is compared against a reference array that is updated only on each write's data edge.

// File: rtl/nbt_pkg.sv
`timescale 1ns/1ps
// Shared types and helpers for the zero-turnaround late-write SRAM.
// Assumes bursts of four words stepping the two low address bits.
package nbt_pkg;

    // Operation carried by an accepted command
    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    // Width of the burst offset field in the address
    localparam int BURST_W = 2;

    // Low address bits for burst offset cnt from base, linear or interleaved
    function automatic logic [BURST_W-1:0] burst_step(
        input logic [BURST_W-1:0] base,
        input logic [BURST_W-1:0] cnt,
        input logic               linear
    );
        return linear ? (base + cnt) : (base ^ cnt);
    endfunction

endpackage

// File: rtl/nbt_cmd_decode.sv
`timescale 1ns/1ps
// Command decoder and burst sequencer.
// Turns the captured control inputs into one operation per enabled edge.
// On a load cycle the three chip selects decide whether a command is
// accepted. On an advance cycle the last loaded operation continues at
// the next burst offset. Sleep blocks new commands and holds the burst
// state. Assumes ADDR_W > BURST_W.
module nbt_cmd_decode
    import nbt_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int NBYTES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              sleep,
    input  logic              lin_order,
    input  logic              load,
    input  logic              wr_n,
    input  logic              cs_a_n,
    input  logic              cs_b,
    input  logic              cs_c_n,
    input  logic [NBYTES-1:0] byte_wr_n,
    input  logic [ADDR_W-1:0] addr,
    output op_e               op,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [NBYTES-1:0] cmd_be_n
);

    logic               sel;
    op_e                b_op;
    logic [ADDR_W-1:0]  b_base;
    logic [BURST_W-1:0] b_cnt;
    logic [BURST_W-1:0] cnt_nxt;

    // Decode the operation and its address for this edge
    always_comb begin
        sel      = !cs_a_n && cs_b && !cs_c_n;
        cnt_nxt  = b_cnt + 1'b1;
        op       = OP_NONE;
        cmd_addr = addr;
        cmd_be_n = byte_wr_n;
        if (!sleep) begin
            if (load) begin
                if (sel) op = wr_n ? OP_READ : OP_WRITE;
            end else begin
                op       = b_op;
                cmd_addr = {b_base[ADDR_W-1:BURST_W],
                            burst_step(b_base[BURST_W-1:0], cnt_nxt, lin_order)};
            end
        end
    end

    // Burst state: the loaded operation, its base address and the offset count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_op   <= OP_NONE;
            b_base <= '0;
            b_cnt  <= '0;
        end else if (en && !sleep) begin
            if (load) begin
                b_op   <= op;
                b_base <= addr;
                b_cnt  <= '0;
            end else if (b_op != OP_NONE) begin
                b_cnt  <= cnt_nxt;
            end
        end
    end

endmodule

// File: rtl/nbt_write_pipe.sv
`timescale 1ns/1ps
// Write-address stages for late write.
// Two stages hold accepted write commands until their data arrives. The
// mode strap picks which stage commits on the current edge and which
// stage will commit on the next edge. The read path uses both for
// forwarding.
module nbt_write_pipe
    import nbt_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int NBYTES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              flow_mode,
    input  op_e               op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [NBYTES-1:0] cmd_be_n,
    output logic              cm_valid,
    output logic [ADDR_W-1:0] cm_addr,
    output logic [NBYTES-1:0] cm_be_n,
    output logic              nx_valid,
    output logic [ADDR_W-1:0] nx_addr,
    output logic [NBYTES-1:0] nx_be_n
);

    logic              s1_v, s2_v;
    logic [ADDR_W-1:0] s1_a, s2_a;
    logic [NBYTES-1:0] s1_b, s2_b;

    // Shift accepted writes through the two stages on enabled edges
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_v <= 1'b0;
            s2_v <= 1'b0;
            s1_a <= '0;
            s2_a <= '0;
            s1_b <= '1;
            s2_b <= '1;
        end else if (en) begin
            s1_v <= (op == OP_WRITE);
            s1_a <= cmd_addr;
            s1_b <= cmd_be_n;
            s2_v <= s1_v;
            s2_a <= s1_a;
            s2_b <= s1_b;
        end
    end

    // Select the committing stage and the next-to-commit stage by mode
    always_comb begin
        cm_valid = flow_mode ? s1_v : s2_v;
        cm_addr  = flow_mode ? s1_a : s2_a;
        cm_be_n  = flow_mode ? s1_b : s2_b;
        nx_valid = !flow_mode && s1_v;
        nx_addr  = s1_a;
        nx_be_n  = s1_b;
    end

endmodule

// File: rtl/nbt_data_path.sv
`timescale 1ns/1ps
// Storage array, coherent read stage and output register.
// Commits late write data per byte lane. The read stage takes the array
// word and overlays bytes being committed on the same edge. The output
// stage overlays bytes of the write that commits one edge later. The
// output drive follows the mode strap and is gated at once by oe_n.
module nbt_data_path #(
    parameter int ADDR_W = 6,
    parameter int NBYTES = 2,
    parameter int BYTE_W = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic                     flow_mode,
    input  logic                     rd_go,
    input  logic [ADDR_W-1:0]        rd_addr,
    input  logic                     cm_valid,
    input  logic [ADDR_W-1:0]        cm_addr,
    input  logic [NBYTES-1:0]        cm_be_n,
    input  logic                     nx_valid,
    input  logic [ADDR_W-1:0]        nx_addr,
    input  logic [NBYTES-1:0]        nx_be_n,
    input  logic [NBYTES*BYTE_W-1:0] din,
    input  logic                     oe_n,
    output logic [NBYTES*BYTE_W-1:0] dout,
    output logic                     dq_oe
);

    localparam int DW    = NBYTES * BYTE_W;
    localparam int DEPTH = 1 << ADDR_W;

    logic [DW-1:0]     mem [DEPTH];
    logic [DW-1:0]     raw, fwd_data, st1, o_next, o_data;
    logic [NBYTES-1:0] now_hit, nxt_hit, fwd_be, late_be;
    logic              rd_v, o_v;

    // Per-lane hit detection and byte overlay
    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        assign now_hit[b] = cm_valid && (cm_addr == rd_addr) && !cm_be_n[b];
        assign nxt_hit[b] = nx_valid && (nx_addr == rd_addr) && !nx_be_n[b];
        assign st1[b*BYTE_W +: BYTE_W] = fwd_be[b] ? fwd_data[b*BYTE_W +: BYTE_W]
                                                   : raw[b*BYTE_W +: BYTE_W];
        assign o_next[b*BYTE_W +: BYTE_W] = late_be[b] ? din[b*BYTE_W +: BYTE_W]
                                                       : st1[b*BYTE_W +: BYTE_W];
    end

    // Commit late write data into enabled lanes
    always_ff @(posedge clk) begin
        if (en && cm_valid) begin
            for (int b = 0; b < NBYTES; b++) begin
                if (!cm_be_n[b]) mem[cm_addr][b*BYTE_W +: BYTE_W] <= din[b*BYTE_W +: BYTE_W];
            end
        end
    end

    // Read the array (old contents) and record the forwarding masks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw      <= '0;
            fwd_data <= '0;
            fwd_be   <= '0;
            late_be  <= '0;
            rd_v     <= 1'b0;
        end else if (en) begin
            raw      <= mem[rd_addr];
            fwd_data <= din;
            fwd_be   <= now_hit;
            late_be  <= nxt_hit;
            rd_v     <= rd_go;
        end
    end

    // Output register used in registered mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_data <= '0;
            o_v    <= 1'b0;
        end else if (en) begin
            o_data <= o_next;
            o_v    <= rd_v;
        end
    end

    // Select the output stage by mode and gate the drive asynchronously
    always_comb begin
        dout  = flow_mode ? st1 : o_data;
        dq_oe = (flow_mode ? rd_v : o_v) && !oe_n;
    end

endmodule

// File: rtl/nbt_sram.sv
`timescale 1ns/1ps
// Zero-turnaround late-write synchronous SRAM, top level.
// Connects the command decoder, the write-address stages and the data
// path. Assumes flow_mode and lin_order are static straps changed only
// under reset.
module nbt_sram
    import nbt_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int NBYTES = 2,
    parameter int BYTE_W = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clk_en_n,
    input  logic                     sleep,
    input  logic                     flow_mode,
    input  logic                     lin_order,
    input  logic                     load,
    input  logic                     wr_n,
    input  logic                     cs_a_n,
    input  logic                     cs_b,
    input  logic                     cs_c_n,
    input  logic [NBYTES-1:0]        byte_wr_n,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [NBYTES*BYTE_W-1:0] din,
    input  logic                     oe_n,
    output logic [NBYTES*BYTE_W-1:0] dout,
    output logic                     dq_oe
);

    localparam int DW = NBYTES * BYTE_W;

    logic              en;
    op_e               op;
    logic [ADDR_W-1:0] cmd_addr, cm_addr, nx_addr;
    logic [NBYTES-1:0] cmd_be_n, cm_be_n, nx_be_n;
    logic              cm_valid, nx_valid;

    assign en = !clk_en_n;

    nbt_cmd_decode #(.ADDR_W(ADDR_W), .NBYTES(NBYTES)) u_dec (
        .clk(clk), .rst_n(rst_n), .en(en), .sleep(sleep), .lin_order(lin_order),
        .load(load), .wr_n(wr_n), .cs_a_n(cs_a_n), .cs_b(cs_b), .cs_c_n(cs_c_n),
        .byte_wr_n(byte_wr_n), .addr(addr),
        .op(op), .cmd_addr(cmd_addr), .cmd_be_n(cmd_be_n)
    );

    nbt_write_pipe #(.ADDR_W(ADDR_W), .NBYTES(NBYTES)) u_wpipe (
        .clk(clk), .rst_n(rst_n), .en(en), .flow_mode(flow_mode),
        .op(op), .cmd_addr(cmd_addr), .cmd_be_n(cmd_be_n),
        .cm_valid(cm_valid), .cm_addr(cm_addr), .cm_be_n(cm_be_n),
        .nx_valid(nx_valid), .nx_addr(nx_addr), .nx_be_n(nx_be_n)
    );

    nbt_data_path #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_data (
        .clk(clk), .rst_n(rst_n), .en(en), .flow_mode(flow_mode),
        .rd_go(op == OP_READ), .rd_addr(cmd_addr),
        .cm_valid(cm_valid), .cm_addr(cm_addr), .cm_be_n(cm_be_n),
        .nx_valid(nx_valid), .nx_addr(nx_addr), .nx_be_n(nx_be_n),
        .din(din), .oe_n(oe_n), .dout(dout), .dq_oe(dq_oe)
    );

endmodule

// File: rtl/nbt_sram_chk.sv
`timescale 1ns/1ps
// Port-level protocol checks for nbt_sram, attached with bind.
// Tracks whether the last enabled edge captured a read so that the
// registered-mode latency can be checked without deep history.
module nbt_sram_chk #(
    parameter int DW = 18
) (
    input logic          clk,
    input logic          rst_n,
    input logic          clk_en_n,
    input logic          sleep,
    input logic          flow_mode,
    input logic          load,
    input logic          wr_n,
    input logic          cs_a_n,
    input logic          cs_b,
    input logic          cs_c_n,
    input logic          oe_n,
    input logic [DW-1:0] dout,
    input logic          dq_oe
);

    logic sel, rd_cmd, pend_rd;

    // Decode a read load command seen at the ports
    always_comb begin
        sel    = !cs_a_n && cs_b && !cs_c_n;
        rd_cmd = !clk_en_n && load && !sleep && sel && wr_n;
    end

    // Remember whether the previous enabled edge captured a read
    always_ff @(posedge clk) begin
        if (!rst_n) pend_rd <= 1'b0;
        else if (!clk_en_n) pend_rd <= rd_cmd;
    end

    // R4
    flow_read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flow_mode && rd_cmd) |=> (dq_oe || oe_n));

    // R3
    pipe_read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flow_mode && !clk_en_n && pend_rd) |=> (dq_oe || oe_n));

    // R2
    deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flow_mode && !clk_en_n && load && !sel) |=> !dq_oe);

    // R9
    freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_n |=> $stable(dout));

    // R10
    oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dq_oe);

endmodule

bind nbt_sram nbt_sram_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .sleep(sleep),
    .flow_mode(flow_mode), .load(load), .wr_n(wr_n), .cs_a_n(cs_a_n),
    .cs_b(cs_b), .cs_c_n(cs_c_n), .oe_n(oe_n), .dout(dout), .dq_oe(dq_oe)
);

// File: tb/nbt_sram_test.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver predicts read results from a reference
// array that is updated on each write's data edge. The monitor pops the
// predictions and compares them as the outputs appear.
module nbt_sram_test;

    localparam int AW = 6;
    localparam int NB = 2;
    localparam int BW = 9;
    localparam int DW = NB * BW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clk_en_n = 1'b0, sleep = 1'b0, flow_mode = 1'b0, lin_order = 1'b1;
    logic          load = 1'b1, wr_n = 1'b1, cs_a_n = 1'b1, cs_b = 1'b1, cs_c_n = 1'b0;
    logic [NB-1:0] byte_wr_n = '1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic          oe_n = 1'b0;
    logic [DW-1:0] dout;
    logic          dq_oe;

    nbt_sram #(.ADDR_W(AW), .NBYTES(NB), .BYTE_W(BW)) uut (
        .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .sleep(sleep),
        .flow_mode(flow_mode), .lin_order(lin_order), .load(load), .wr_n(wr_n),
        .cs_a_n(cs_a_n), .cs_b(cs_b), .cs_c_n(cs_c_n), .byte_wr_n(byte_wr_n),
        .addr(addr), .din(din), .oe_n(oe_n), .dout(dout), .dq_oe(dq_oe)
    );

    always #10 clk = ~clk;

    int errors = 0, checks = 0, edge_cnt = 0, last_seen = -1, seq = 0;
    bit mon_on = 0, done = 0;
    logic [DW-1:0] ref_mem [1<<AW];
    int            p_due[$];
    logic [AW-1:0] p_addr[$];
    logic [NB-1:0] p_be[$];
    logic [DW-1:0] p_dat[$];
    int            e_due[$];
    logic [DW-1:0] e_dat[$];
    string         e_tag[$];
    int            m_op = 0;
    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_cnt = '0;

    function automatic logic [DW-1:0] merge(input logic [DW-1:0] old_w,
                                            input logic [DW-1:0] new_w,
                                            input logic [NB-1:0] be_n);
        logic [DW-1:0] r = old_w;
        for (int b = 0; b < NB; b++)
            if (!be_n[b]) r[b*BW +: BW] = new_w[b*BW +: BW];
        return r;
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    function automatic logic [DW-1:0] next_data();
        seq++;
        return DW'(seq * 1237 + 5);
    endfunction

    // One enabled edge carrying a command; model updated after the edge
    task automatic drive(input bit ld, input bit wr, input int selv,
                         input logic [AW-1:0] a, input logic [NB-1:0] ben,
                         input logic [DW-1:0] wd, input bit slp, input bit oeoff,
                         input string tag);
        logic [DW-1:0] dv, ex;
        logic [AW-1:0] ia;
        int op;
        @(negedge clk);
        dv = '0;
        foreach (p_due[i]) if (p_due[i] == edge_cnt + 1) dv = p_dat[i];
        clk_en_n = 0; load = ld; wr_n = !wr;
        cs_a_n = (selv == 1); cs_b = (selv != 2); cs_c_n = (selv == 3);
        addr = a; byte_wr_n = ben; din = dv; sleep = slp; oe_n = oeoff;
        @(posedge clk);
        edge_cnt++;
        while (p_due.size() > 0 && p_due[0] == edge_cnt) begin
            ref_mem[p_addr[0]] = merge(ref_mem[p_addr[0]], p_dat[0], p_be[0]);
            void'(p_due.pop_front()); void'(p_addr.pop_front());
            void'(p_be.pop_front());  void'(p_dat.pop_front());
        end
        op = 0; ia = a;
        if (!slp) begin
            if (ld) begin
                if (selv == 0) op = wr ? 2 : 1;
                m_op = op; m_base = a; m_cnt = '0;
            end else if (m_op != 0) begin
                m_cnt = m_cnt + 2'd1;
                op = m_op;
                ia = {m_base[AW-1:2], lin_order ? 2'(m_base[1:0] + m_cnt) : (m_base[1:0] ^ m_cnt)};
            end
        end
        if (op == 2) begin
            p_due.push_back(edge_cnt + (flow_mode ? 1 : 2));
            p_addr.push_back(ia); p_be.push_back(ben); p_dat.push_back(wd);
        end else if (op == 1) begin
            ex = ref_mem[ia];
            foreach (p_due[i]) if (p_addr[i] == ia) ex = merge(ex, p_dat[i], p_be[i]);
            e_due.push_back(edge_cnt + (flow_mode ? 0 : 1));
            e_dat.push_back(ex); e_tag.push_back(tag);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [NB-1:0] ben = '0);
        drive(1, 1, 0, a, ben, next_data(), 0, 0, "");
    endtask

    task automatic rd(input logic [AW-1:0] a, input string tag);
        drive(1, 0, 0, a, '1, '0, 0, 0, tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(1, 0, 1, '0, '1, '0, 0, 0, "");
    endtask

    // Disabled edges with garbage on every input; outputs must hold (R9)
    task automatic stall(input int n);
        logic [DW-1:0] pd;
        logic po;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            pd = dout; po = dq_oe;
            clk_en_n = 1; din = DW'(32'h2A5A5 + i); load = 1; wr_n = 0;
            cs_a_n = 0; cs_b = 1; cs_c_n = 0; addr = ~addr; byte_wr_n = '0;
            @(posedge clk); #5;
            check(dout == pd && dq_oe == po, "R9 freeze hold", dout, pd);
        end
    endtask

    // Monitor: compare due predictions, otherwise the bus must be idle
    always begin
        @(posedge clk); #5;
        if (mon_on && edge_cnt != last_seen) begin
            last_seen = edge_cnt;
            if (e_due.size() > 0 && e_due[0] == edge_cnt) begin
                check(dq_oe == !oe_n, {e_tag[0], " drive"}, DW'(dq_oe), DW'(!oe_n));
                if (!oe_n) check(dout == e_dat[0], e_tag[0], dout, e_dat[0]);
                void'(e_due.pop_front()); void'(e_dat.pop_front()); void'(e_tag.pop_front());
            end else begin
                check(dq_oe == 1'b0, "R2 bus idle", DW'(dq_oe), '0);
            end
        end
    end

    task automatic phase(input bit fl, input bit ln);
        mon_on = 0;
        @(negedge clk);
        rst_n = 0; flow_mode = fl; lin_order = ln; clk_en_n = 0; load = 1;
        cs_a_n = 1; oe_n = 0; sleep = 0;
        repeat (3) @(posedge clk);
        p_due.delete(); p_addr.delete(); p_be.delete(); p_dat.delete();
        e_due.delete(); e_dat.delete(); e_tag.delete(); m_op = 0;
        @(negedge clk); rst_n = 1;
        @(posedge clk); #5;
        check(dq_oe == 1'b0, "R1 reset idle", DW'(dq_oe), '0);
        last_seen = edge_cnt; mon_on = 1;
        // R5 plain writes then readback (R3 / R4 latency)
        for (int a = 0; a < 8; a++) wr(AW'(a));
        for (int a = 0; a < 8; a++) rd(AW'(a), fl ? "R4 R5 readback" : "R3 R5 readback");
        // R7 forwarding: adjacent and with one gap
        wr(10); rd(10, "R7 forward adjacent");
        wr(11); rd(3, "R7 other word"); rd(11, "R7 forward gap");
        // R6 two partial writes in flight, then read at once
        wr(12); wr(12, 2'b10); wr(12, 2'b01); rd(12, "R6 R7 dual forward");
        idle(3); rd(12, "R6 committed merge");
        wr(13); idle(3); wr(13, 2'b01); idle(3); rd(13, "R6 upper lane only");
        // R12 and R2: deselect bubbles between command and data
        wr(20);
        drive(1, 0, 1, 20, '1, '0, 0, 0, "");
        drive(1, 0, 2, 20, '1, '0, 0, 0, "");
        drive(1, 0, 3, 20, '1, '0, 0, 0, "");
        rd(20, "R12 write survives bubbles");
        // R11 sleep ignores commands but pending writes complete
        wr(22); idle(3); wr(21);
        drive(1, 1, 0, 22, '0, next_data(), 1, 0, "");
        drive(1, 0, 0, 21, '1, '0, 1, 0, "");
        rd(21, "R11 pending write completes"); rd(22, "R11 sleep write ignored");
        // R8 burst write turned into burst read with no gap
        drive(1, 1, 0, 37, '0, next_data(), 0, 0, "");
        for (int i = 0; i < 3; i++) drive(0, 0, 0, '0, 2'(i), next_data(), 0, 0, "");
        drive(1, 0, 0, 37, '1, '0, 0, 0, "R8 burst base");
        for (int i = 0; i < 3; i++) drive(0, 1, 0, '0, '1, '0, 0, 0, "R8 burst step");
        // R9 clock-enable freeze in flight
        wr(40); stall(2); rd(40, "R9 R7 stall forward");
        stall(2); rd(0, "R9 resume"); stall(1); idle(2);
        // R10 asynchronous output disable
        wr(41); idle(2);
        drive(1, 0, 0, 41, '1, '0, 0, 1, "R10 oe off");
        rd(41, "R10 oe on");
        idle(4);
        check(e_due.size() == 0, "R3 all reads seen", DW'(e_due.size()), '0);
    endtask

    initial begin
        phase(0, 1);
        phase(1, 0);
        mon_on = 0;
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule